// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block is the counting core of a real-time clock. Seven byte fields hold seconds, minutes, hours, weekday, day of month, month and a two-digit year. Every count is kept in packed BCD, and the year stands for 2000 through 2099. A single-cycle one-second pulse from an external prescaler advances the seconds. Carries ripple upward through the fields, and month lengths and leap years are applied to the day of month.

The hour byte can run in a 24-hour form or a 12-hour form with an AM/PM flag, and the form is chosen by a bit inside that byte. Software loads any field through a byte write port. It reads any field through a combinational read port. A halt input freezes timekeeping while writes stay allowed. A write that arrives in the same cycle as a tick takes priority, and that tick is dropped, so the prescaler can be restarted by the same write and the next second counts from the load.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00.
- R2: Each accepted tick adds one to the seconds in BCD. Seconds 0x59 wrap to 0x00 and add one to the minutes. Minutes 0x59 wrap to 0x00 and carry into the hour.
- R3: With hour bit 6 clear (24-hour form), a carry into hour 0x23 gives 0x00 and advances the weekday and the date.
- R4: With hour bit 6 set (12-hour form), bit 5 is PM and bits 4:0 count BCD 12,01..11. 11 goes to 12 with bit 5 inverted, 12 goes to 01 with bit 5 kept, and bit 6 stays set. Only 11 PM going to 12 AM advances the weekday and the date.
- R5: The weekday (field 3) counts 1..7 and goes from 7 to 1 on a day carry.
- R6: The date returns to 0x01 and the month advances after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in every other month except 0x02.
- R7: In month 0x02 the last date is 0x29 when the BCD year is a multiple of four (00 counted), and 0x28 otherwise.
- R8: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R9: While haltOsc is 1, ticks are ignored and every field holds. Writes still load.
- R10: wrEn with wrAddr 0..6 (0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year) stores wrData in that field at the next edge. wrAddr 7 changes nothing. A tick that arrives with a write is discarded, and no other field moves.
- R11: rdData shows the field chosen by rdAddr (same map as R10) in the same cycle. rdAddr 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| haltOsc | input | 1 | 1 stops timekeeping |
| wrEn | input | 1 | Field write strobe |
| wrAddr | input | 3 | Field index for a write |
| wrData | input | 8 | Byte to load |
| rdAddr | input | 3 | Field index for a read |
| rdData | output | 8 | Selected field value |

## Verification
Every field is one register stage from the tick or write strobe. A result is therefore due at the first rising edge after the strobe is held high. The read port adds no latency. The bench drives all strobes at the falling edge, holds them for exactly one rising edge, and drops them at the next falling edge. It then sets rdAddr and samples rdData a short delay later, well before the following rising edge. Roll-over cases are set up by loading the fields first and then issuing a single tick, so each expected value is the result of exactly one counted step.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W    = 8;
  localparam int FIELD_CNT = 7;
  localparam int ADDR_W    = $clog2(FIELD_CNT + 1);
  localparam int HR_MODE   = 6;
  localparam int HR_PM     = 5;
  localparam int HR_NUM_W  = 5;

  // field order is the software address map
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [FIELD_CNT-1:0][BYTE_W-1:0] calFields_t;

  typedef struct packed {
    logic [FIELD_CNT-1:0] step;
    logic [FIELD_CNT-1:0] wrap;
    logic [FIELD_CNT-1:0] load;
  } calStrobe_t;

  function automatic logic [BYTE_W-1:0] fieldFloor(input int idx);
    case (idx)
      F_WDAY, F_DATE, F_MON: fieldFloor = BYTE_W'(1);
      default:               fieldFloor = '0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic              tick,
  input  logic              haltOsc,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  calFields_t        fieldQ,
  output calStrobe_t        strobe
);
  logic advance;
  logic leapYear;
  logic [BYTE_W-1:0] lastDate;
  logic [BYTE_W-1:0] hourQ;
  logic [BYTE_W-1:0] monQ;
  logic [BYTE_W-1:0] yearQ;

  assign hourQ = fieldQ[F_HOUR];
  assign monQ  = fieldQ[F_MON];
  assign yearQ = fieldQ[F_YEAR];

  assign advance = tick & ~haltOsc & ~wrEn;

  // BCD multiple of four: even tens with units 0/4/8, odd tens with 2/6
  always_comb begin
    if (!yearQ[4])
      leapYear = (yearQ[3:0] == 4'd0) || (yearQ[3:0] == 4'd4) || (yearQ[3:0] == 4'd8);
    else
      leapYear = (yearQ[3:0] == 4'd2) || (yearQ[3:0] == 4'd6);
  end

  always_comb begin
    case (monQ)
      8'h02:                    lastDate = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDate = 8'h30;
      default:                  lastDate = 8'h31;
    endcase
  end

  always_comb begin
    strobe.wrap = '0;
    strobe.wrap[F_SEC]  = fieldQ[F_SEC]  == 8'h59;
    strobe.wrap[F_MIN]  = fieldQ[F_MIN]  == 8'h59;
    strobe.wrap[F_HOUR] = hourQ[HR_MODE] ?
                          (hourQ[HR_PM] && hourQ[HR_NUM_W-1:0] == 5'h11) :
                          (hourQ == 8'h23);
    strobe.wrap[F_WDAY] = fieldQ[F_WDAY] == 8'h07;
    strobe.wrap[F_DATE] = fieldQ[F_DATE] == lastDate;
    strobe.wrap[F_MON]  = monQ  == 8'h12;
    strobe.wrap[F_YEAR] = yearQ == 8'h99;
  end

  always_comb begin
    strobe.step = '0;
    strobe.step[F_SEC]  = advance;
    strobe.step[F_MIN]  = strobe.step[F_SEC]  & strobe.wrap[F_SEC];
    strobe.step[F_HOUR] = strobe.step[F_MIN]  & strobe.wrap[F_MIN];
    strobe.step[F_WDAY] = strobe.step[F_HOUR] & strobe.wrap[F_HOUR];
    strobe.step[F_DATE] = strobe.step[F_HOUR] & strobe.wrap[F_HOUR];
    strobe.step[F_MON]  = strobe.step[F_DATE] & strobe.wrap[F_DATE];
    strobe.step[F_YEAR] = strobe.step[F_MON]  & strobe.wrap[F_MON];
  end

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_load
    assign strobe.load[i] = wrEn && (wrAddr == ADDR_W'(i));
  end
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  output calFields_t        fieldQ
);
  function automatic logic [BYTE_W-1:0] hourNext(input logic [BYTE_W-1:0] h);
    logic [BYTE_W-1:0] num;
    num = {{(BYTE_W-HR_NUM_W){1'b0}}, h[HR_NUM_W-1:0]};
    if (h[HR_MODE]) begin
      if (num == 8'h12)      hourNext = {2'b01, h[HR_PM], 5'h01};
      else if (num == 8'h11) hourNext = {2'b01, ~h[HR_PM], 5'h12};
      else                   hourNext = {2'b01, h[HR_PM], bcdInc(num)[HR_NUM_W-1:0]};
    end else begin
      hourNext = (h == 8'h23) ? 8'h00 : bcdInc(h);
    end
  endfunction

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_field
    if (i == F_HOUR) begin : g_hour
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                fieldQ[i] <= '0;
        else if (strobe.load[i])  fieldQ[i] <= wrData;
        else if (strobe.step[i])  fieldQ[i] <= hourNext(fieldQ[i]);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                fieldQ[i] <= fieldFloor(i);
        else if (strobe.load[i])  fieldQ[i] <= wrData;
        else if (strobe.step[i])  fieldQ[i] <= strobe.wrap[i] ? fieldFloor(i) : bcdInc(fieldQ[i]);
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              haltOsc,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData
);
  calFields_t fieldQ;
  calStrobe_t strobe;

  rtc_cal_ctrl u_ctrl (
    .tick    (tick),
    .haltOsc (haltOsc),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .fieldQ  (fieldQ),
    .strobe  (strobe)
  );

  rtc_cal_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .fieldQ (fieldQ)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < FIELD_CNT; i++)
      if (rdAddr == ADDR_W'(i)) rdData = fieldQ[i];
  end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              haltOsc,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input calFields_t        fieldQ
);
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (haltOsc && !wrEn) |=> $stable(fieldQ));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !haltOsc && !wrEn && fieldQ[F_SEC] == 8'h59) |=> (fieldQ[F_SEC] == 8'h00));

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !(tick && !haltOsc && fieldQ[F_SEC] == 8'h59)) |=> $stable(fieldQ[F_MIN]));

  p_mode_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> (fieldQ[F_HOUR][HR_MODE] == $past(fieldQ[F_HOUR][HR_MODE])));

  p_tick_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != ADDR_W'(F_SEC)) |=> $stable(fieldQ[F_SEC]));

  for (genvar i = 0; i < FIELD_CNT; i++) begin : g_ld
    p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(i)) |=> (fieldQ[i] == $past(wrData)));
  end
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .haltOsc (haltOsc),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .fieldQ  (fieldQ)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic       tick = 0;
  logic       haltOsc = 0;
  logic       wrEn = 0;
  logic [2:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic [2:0] rdAddr = 0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .haltOsc(haltOsc),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expectField(input string tag, input int a, input logic [7:0] exp);
    rdAddr = 3'(a);
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s field %0d actual %h expected %h", tag, a, rdData, exp);
    end
  endtask

  task automatic putField(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic pulseTick();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    putField(2, h); putField(1, m); putField(0, s);
  endtask

  task automatic testReset();
    expectField("R1", 0, 8'h00); expectField("R1", 1, 8'h00);
    expectField("R1", 2, 8'h00); expectField("R1", 3, 8'h01);
    expectField("R1", 4, 8'h01); expectField("R1", 5, 8'h01);
    expectField("R1", 6, 8'h00);
    expectField("R11", 7, 8'h00);
  endtask

  task automatic testSeconds();
    putField(0, 8'h08);
    pulseTick(); expectField("R2", 0, 8'h09);
    pulseTick(); expectField("R2", 0, 8'h10);
    setTime(8'h05, 8'h09, 8'h59);
    pulseTick();
    expectField("R2", 0, 8'h00); expectField("R2", 1, 8'h10);
    expectField("R2", 2, 8'h05);
    setTime(8'h09, 8'h59, 8'h59);
    pulseTick();
    expectField("R2", 1, 8'h00); expectField("R2", 2, 8'h10);
  endtask

  task automatic test24h();
    putField(3, 8'h07); putField(4, 8'h15); putField(5, 8'h03);
    setTime(8'h23, 8'h59, 8'h59);
    pulseTick();
    expectField("R3", 2, 8'h00); expectField("R3", 0, 8'h00);
    expectField("R5", 3, 8'h01); expectField("R3", 4, 8'h16);
  endtask

  task automatic test12h();
    putField(3, 8'h02); putField(4, 8'h10); putField(5, 8'h03);
    setTime(8'h51, 8'h59, 8'h59);
    pulseTick();
    expectField("R4", 2, 8'h72); expectField("R4", 4, 8'h10);
    setTime(8'h72, 8'h59, 8'h59);
    pulseTick();
    expectField("R4", 2, 8'h61);
    setTime(8'h71, 8'h59, 8'h59);
    pulseTick();
    expectField("R4", 2, 8'h52); expectField("R4", 4, 8'h11);
    expectField("R5", 3, 8'h03);
    setTime(8'h52, 8'h59, 8'h59);
    pulseTick();
    expectField("R4", 2, 8'h41);
    setTime(8'h49, 8'h59, 8'h59);
    pulseTick();
    expectField("R4", 2, 8'h50);
  endtask

  task automatic testMonthLen();
    putField(5, 8'h04); putField(4, 8'h30);
    setTime(8'h23, 8'h59, 8'h59);
    pulseTick();
    expectField("R6", 4, 8'h01); expectField("R6", 5, 8'h05);
    putField(4, 8'h30);
    setTime(8'h23, 8'h59, 8'h59);
    pulseTick();
    expectField("R6", 4, 8'h31); expectField("R6", 5, 8'h05);
    putField(5, 8'h11); putField(4, 8'h30);
    setTime(8'h23, 8'h59, 8'h59);
    pulseTick();
    expectField("R6", 4, 8'h01); expectField("R6", 5, 8'h12);
  endtask

  task automatic testLeap();
    putField(6, 8'h24); putField(5, 8'h02); putField(4, 8'h28);
    setTime(8'h23, 8'h59, 8'h59); pulseTick();
    expectField("R7", 4, 8'h29); expectField("R7", 5, 8'h02);
    setTime(8'h23, 8'h59, 8'h59); pulseTick();
    expectField("R7", 4, 8'h01); expectField("R7", 5, 8'h03);
    putField(6, 8'h10); putField(5, 8'h02); putField(4, 8'h28);
    setTime(8'h23, 8'h59, 8'h59); pulseTick();
    expectField("R7", 4, 8'h01); expectField("R7", 5, 8'h03);
    putField(6, 8'h00); putField(5, 8'h02); putField(4, 8'h28);
    setTime(8'h23, 8'h59, 8'h59); pulseTick();
    expectField("R7", 4, 8'h29);
  endtask

  task automatic testYear();
    putField(6, 8'h99); putField(5, 8'h12); putField(4, 8'h31);
    setTime(8'h23, 8'h59, 8'h59); pulseTick();
    expectField("R8", 4, 8'h01); expectField("R8", 5, 8'h01);
    expectField("R8", 6, 8'h00);
    putField(6, 8'h19); putField(5, 8'h12); putField(4, 8'h31);
    setTime(8'h23, 8'h59, 8'h59); pulseTick();
    expectField("R8", 6, 8'h20);
  endtask

  task automatic testHalt();
    setTime(8'h10, 8'h20, 8'h59);
    haltOsc = 1;
    pulseTick(); pulseTick(); pulseTick();
    expectField("R9", 0, 8'h59); expectField("R9", 1, 8'h20);
    putField(0, 8'h33);
    expectField("R9", 0, 8'h33);
    haltOsc = 0;
    pulseTick();
    expectField("R9", 0, 8'h34);
  endtask

  task automatic testWrite();
    setTime(8'h08, 8'h05, 8'h20);
    putField(7, 8'h45);
    for (int a = 0; a < 7; a++) begin
      rdAddr = 3'(a); #1;
      checks++;
      if (a == 0 && rdData !== 8'h20) begin
        errors++; $display("FAIL R10 addr7 write sec actual %h expected 20", rdData);
      end
    end
    expectField("R10", 1, 8'h05); expectField("R10", 2, 8'h08);
    @(negedge clk);
    tick = 1; wrEn = 1; wrAddr = 3'd1; wrData = 8'h30;
    @(negedge clk);
    tick = 0; wrEn = 0;
    expectField("R10", 0, 8'h20); expectField("R10", 1, 8'h30);
    putField(6, 8'h57); expectField("R11", 6, 8'h57);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSeconds();
    test24h();
    test12h();
    testMonthLen();
    testLeap();
    testYear();
    testHalt();
    testWrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule